// File: doc/BRIEF.md
# Generative Tile Exposure Mask Engine

This block computes the expose bit for every pixel of a coded-exposure sensor while it scans, so no per-subframe mask has to be stored. Each pixel carries a 2-bit exponent `t` that places it in a square tile of side `N = 2^t`. Within a tile, pixels take turns: on each subframe at most one pixel of the tile is exposed. Tiles smaller than the largest allowed tile are spread out in time so that every tile size repeats with the same period. That period is `Lmax = Nmax²` subframes, where `Nmax = 2^m` and `m` is the run-time maximum exponent.

The engine walks the array in raster order, one pixel per enabled clock. It presents the current column and row on a lookup port, and the surrounding logic answers on the same cycle with that pixel's tile code. One cycle later the engine emits the mask bit, together with a valid strobe, an end-of-row marker and an end-of-frame marker. The subframe number advances after the last pixel of each frame.

The image width, the image height and the maximum exponent are inputs, so one tile map serves any resolution and any number of subframes. The in-tile position terms are produced by one rollover counter per supported tile size instead of by modulo arithmetic.

Top module: `mask_tile_engine`

## Requirements
- R1: After reset, `valid_o`, `mask_o`, `eol_o`, `eof_o` and `code_err_o` are 0, `subframe_o` is 0, and the lookup position (`map_col_o`, `map_row_o`) is column 0, row 0.
- R2: Each clock with `enable_i` high advances the lookup position by one pixel. The column increases first; after column `cfg_width_i-1` the column returns to 0 and the row increases; after the last row the row returns to 0.
- R3: The outputs for the pixel presented on a given clock edge appear after that edge, with `valid_o` high. `eol_o` is high for the pixel in the last column, and `eof_o` is high for the pixel in the last column of the last row.
- R4: `subframe_o` is a 16-bit count. It increments on the same edge that emits `eof_o`, changes at no other time, and wraps from 0xFFFF to 0.
- R5: A pixel with exponent `t` (tile side `N = 2^t`) has in-tile index `(c mod N) + N·(r mod N)`. For example, with 2×2 tiles and `m = 1`, the top-right pixel of a tile is the one exposed on subframes with `s mod 4 = 1`.
- R6: With phase `p = s mod 4^m` and stride `4^(m-t)`, the mask bit is 1 exactly when `p` is a multiple of the stride and `p / stride` equals the pixel's in-tile index.
- R7: Over any `4^m` consecutive subframes, every pixel is exposed exactly once.
- R8: A tile code greater than `cfg_max_exp_i` is evaluated as `cfg_max_exp_i`, and `code_err_o` rises and stays high until reset.
- R9: While `enable_i` is low, `valid_o`, `eol_o` and `eof_o` are 0, and the lookup position and `subframe_o` do not change.
- R10: Width, height and maximum exponent are taken from the configuration inputs at run time, so frames of different sizes and tile periods run on the same instance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Scan one pixel on this clock |
| cfg_width_i | input | COL_W | Number of columns |
| cfg_height_i | input | ROW_W | Number of rows |
| cfg_max_exp_i | input | 2 | Maximum tile exponent m |
| map_code_i | input | 2 | Tile exponent of the pixel at the lookup position |
| map_col_o | output | COL_W | Column of the pixel being looked up |
| map_row_o | output | ROW_W | Row of the pixel being looked up |
| mask_o | output | 1 | Expose bit |
| valid_o | output | 1 | Mask bit is valid |
| eol_o | output | 1 | Pixel was the last in its row |
| eof_o | output | 1 | Pixel was the last in the frame |
| subframe_o | output | 16 | Current subframe number |
| code_err_o | output | 1 | Sticky flag: a tile code exceeded the maximum |

## Verification
The bench goes after places where the index and the phase can slip against each other, by sweeping every maximum exponent over a full period.

- If the row-major order were swapped, the 2×2 case would expose the bottom-left pixel on subframe phase 1 instead of the top-right pixel.
- If a stride were wrong, or a tile counter rolled over at the wrong limit on a width that is not a multiple of the tile, a pixel would be exposed twice or never within one period.
- An off-by-one in the end-of-row or end-of-frame test would shift every later mask bit, and would be caught at the markers.
- A flag that cleared itself, an unclamped out-of-range code, a subframe step during idle cycles, and a missing 16-bit wrap are each checked at the ports.

// File: rtl/mask_pkg.sv
package mask_pkg;
    localparam int EXP_W   = 2;
    localparam int MAX_EXP = (1 << EXP_W) - 1;
    localparam int SUB_W   = 16;
    localparam int IDX_W   = 2 * MAX_EXP;

    typedef logic [EXP_W-1:0] exp_t;
    typedef logic [SUB_W-1:0] sub_t;
    typedef logic [MAX_EXP:0][MAX_EXP-1:0] mod_vec_t;

    function automatic exp_t clamp_exp(exp_t code, exp_t lim);
        return (code > lim) ? lim : code;
    endfunction
endpackage

// File: rtl/mask_roll_counters.sv
module mask_roll_counters
    import mask_pkg::*;
#(
    parameter int POS_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic             wrap_i,
    input  logic [POS_W-1:0] pos_i,
    output mod_vec_t         mod_o
);
    // tile side 1: the in-tile offset is always zero
    assign mod_o[0] = '0;

    for (genvar k = 1; k <= MAX_EXP; k++) begin : g_size
        localparam logic [k-1:0] LIMIT = '1;
        logic [k-1:0] cnt_d, cnt_q;

        always_comb begin
            cnt_d = cnt_q;
            if (wrap_i) begin
                cnt_d = '0;
            end else if (step_i) begin
                cnt_d = (cnt_q == LIMIT) ? '0 : cnt_q + 1'b1;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cnt_q <= '0;
            else        cnt_q <= cnt_d;
        end

        assign mod_o[k] = MAX_EXP'(cnt_q);

        // R5: rollover counter stays equal to the position modulo 2^k
        a_r5_counter_tracks_pos: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q == pos_i[k-1:0]);
    end
endmodule

// File: rtl/mask_expose_eval.sv
module mask_expose_eval
    import mask_pkg::*;
(
    input  sub_t     sub_i,
    input  exp_t     t_i,
    input  exp_t     m_i,
    input  mod_vec_t col_mod_i,
    input  mod_vec_t row_mod_i,
    output logic     expose_o
);
    logic [MAX_EXP-1:0] cm, rm;
    logic [IDX_W-1:0]   idx, phase, low_mask;
    logic [2:0]         gap;
    exp_t               span;

    always_comb begin
        cm       = col_mod_i[t_i];
        rm       = row_mod_i[t_i];
        idx      = IDX_W'(cm) | (IDX_W'(rm) << t_i);
        phase    = sub_i[IDX_W-1:0] & ~({IDX_W{1'b1}} << {m_i, 1'b0});
        span     = m_i - t_i;
        gap      = {span, 1'b0};
        low_mask = ~({IDX_W{1'b1}} << gap);
        expose_o = ((phase & low_mask) == '0) && ((phase >> gap) == idx);
    end
endmodule

// File: rtl/mask_tile_engine.sv
module mask_tile_engine
    import mask_pkg::*;
#(
    parameter int COL_W = 10,
    parameter int ROW_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic [COL_W-1:0] cfg_width_i,
    input  logic [ROW_W-1:0] cfg_height_i,
    input  logic [1:0]       cfg_max_exp_i,
    input  logic [1:0]       map_code_i,
    output logic [COL_W-1:0] map_col_o,
    output logic [ROW_W-1:0] map_row_o,
    output logic             mask_o,
    output logic             valid_o,
    output logic             eol_o,
    output logic             eof_o,
    output logic [15:0]      subframe_o,
    output logic             code_err_o
);
    typedef struct packed {
        logic [COL_W-1:0] col;
        logic [ROW_W-1:0] row;
        sub_t             sub;
        logic             mask;
        logic             valid;
        logic             eol;
        logic             eof;
        logic             err;
    } state_t;

    state_t   st_d, st_q;
    logic     last_col, last_row, expose, code_bad;
    exp_t     t_eff;
    mod_vec_t col_mod, row_mod;

    assign last_col = ({1'b0, st_q.col} + (COL_W+1)'(1)) >= {1'b0, cfg_width_i};
    assign last_row = ({1'b0, st_q.row} + (ROW_W+1)'(1)) >= {1'b0, cfg_height_i};
    assign code_bad = map_code_i > cfg_max_exp_i;
    assign t_eff    = clamp_exp(map_code_i, cfg_max_exp_i);

    mask_roll_counters #(.POS_W(COL_W)) i_col_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (enable_i),
        .wrap_i (enable_i && last_col),
        .pos_i  (st_q.col),
        .mod_o  (col_mod)
    );

    mask_roll_counters #(.POS_W(ROW_W)) i_row_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (enable_i && last_col),
        .wrap_i (enable_i && last_col && last_row),
        .pos_i  (st_q.row),
        .mod_o  (row_mod)
    );

    mask_expose_eval i_eval (
        .sub_i     (st_q.sub),
        .t_i       (t_eff),
        .m_i       (cfg_max_exp_i),
        .col_mod_i (col_mod),
        .row_mod_i (row_mod),
        .expose_o  (expose)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.mask  = 1'b0;
        st_d.eol   = 1'b0;
        st_d.eof   = 1'b0;
        if (enable_i) begin
            st_d.valid = 1'b1;
            st_d.mask  = expose;
            st_d.eol   = last_col;
            st_d.eof   = last_col && last_row;
            st_d.err   = st_q.err || code_bad;
            if (last_col) begin
                st_d.col = '0;
                if (last_row) begin
                    st_d.row = '0;
                    st_d.sub = st_q.sub + 1'b1;
                end else begin
                    st_d.row = st_q.row + 1'b1;
                end
            end else begin
                st_d.col = st_q.col + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign map_col_o  = st_q.col;
    assign map_row_o  = st_q.row;
    assign mask_o     = st_q.mask;
    assign valid_o    = st_q.valid;
    assign eol_o      = st_q.eol;
    assign eof_o      = st_q.eof;
    assign subframe_o = st_q.sub;
    assign code_err_o = st_q.err;

    // R3: a pixel flagged as last in its row leaves the scan at column 0
    a_r3_eol_wraps_col: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.valid && st_q.eol) |-> (st_q.col == '0));

    // R4: the subframe number only moves together with end of frame
    a_r4_sub_moves_on_eof: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.sub != $past(st_q.sub)) |-> (st_q.eof && st_q.valid));

    // R8: the code error flag never clears on its own
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.err |=> st_q.err);

    // R9: an idle cycle emits nothing and keeps the scan position
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> (!st_q.valid && $stable(st_q.col) && $stable(st_q.row)
                       && $stable(st_q.sub)));
endmodule

// File: tb/test_mask_tile_engine.sv
module test_mask_tile_engine;
    localparam int COL_W = 10;
    localparam int ROW_W = 10;
    localparam int WATCHDOG = 190000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             enable = 1'b0;
    logic [COL_W-1:0] cfg_width = 10'd4;
    logic [ROW_W-1:0] cfg_height = 10'd2;
    logic [1:0]       cfg_max_exp = 2'd0;
    logic [1:0]       map_code;
    logic [COL_W-1:0] map_col;
    logic [ROW_W-1:0] map_row;
    logic             mask, valid, eol, eof, code_err;
    logic [15:0]      subframe;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 0;
    int mc, mr, ms;
    int cur_w, cur_h, cur_m;
    int fixed_code = -1;
    bit bad_on = 0;
    int cnt[0:15][0:7];
    logic [63:0] frame_bits;

    always #10 clk = ~clk;

    mask_tile_engine #(.COL_W(COL_W), .ROW_W(ROW_W)) i_mask_tile_engine (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable_i      (enable),
        .cfg_width_i   (cfg_width),
        .cfg_height_i  (cfg_height),
        .cfg_max_exp_i (cfg_max_exp),
        .map_code_i    (map_code),
        .map_col_o     (map_col),
        .map_row_o     (map_row),
        .mask_o        (mask),
        .valid_o       (valid),
        .eol_o         (eol),
        .eof_o         (eof),
        .subframe_o    (subframe),
        .code_err_o    (code_err)
    );

    function automatic int code_at(int c, int r, int m, int fixed, bit bad);
        if (bad && c == 1 && r == 0) return 3;
        if (fixed >= 0) return fixed;
        return ((c >> 2) + (r >> 1)) % (m + 1);
    endfunction

    always_comb map_code = 2'(code_at(int'(map_col), int'(map_row), cur_m, fixed_code, bad_on));

    function automatic bit model_expose(int c, int r, int s, int m, int code);
        int t, n, idx, lmax, stride, phase;
        t      = (code > m) ? m : code;
        n      = 1 << t;
        idx    = (c % n) + n * (r % n);
        lmax   = 1 << (2 * m);
        stride = lmax / (n * n);
        phase  = s % lmax;
        return (phase % stride == 0) && (phase / stride == idx);
    endfunction

    task automatic check_eq(string req, string what, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG && !done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected at most %0d", cyc, WATCHDOG);
            summary();
            $finish;
        end
    end

    // R10: configuration is applied at a frame boundary
    task automatic configure(int w, int h, int m);
        enable      = 1'b0;
        cur_w       = w;
        cur_h       = h;
        cur_m       = m;
        cfg_width   = COL_W'(w);
        cfg_height  = ROW_W'(h);
        cfg_max_exp = 2'(m);
        mc = 0;
        mr = 0;
        @(posedge clk);
        @(negedge clk);
        ms = int'(subframe);
    endtask

    task automatic run_pixels(int n, bit do_check);
        for (int i = 0; i < n; i++) begin
            bit e, lc, lr;
            if (do_check) begin
                check_eq("R2", "lookup column", int'(map_col), mc);
                check_eq("R2", "lookup row", int'(map_row), mr);
            end
            e  = model_expose(mc, mr, ms, cur_m, code_at(mc, mr, cur_m, fixed_code, bad_on));
            lc = (mc == cur_w - 1);
            lr = (mr == cur_h - 1);
            enable = 1'b1;
            @(posedge clk);
            @(negedge clk);
            if (i < 64) frame_bits[i] = mask;
            if (mask && mc < 16 && mr < 8) cnt[mc][mr]++;
            if (do_check) begin
                check_eq("R3", "valid", int'(valid), 1);
                check_eq("R6", "mask", int'(mask), int'(e));
                check_eq("R3", "end of row", int'(eol), int'(lc));
                check_eq("R3", "end of frame", int'(eof), int'(lc && lr));
            end
            if (lc) begin
                mc = 0;
                if (lr) begin
                    mr = 0;
                    ms = (ms + 1) & 16'hFFFF;
                    if (do_check) check_eq("R4", "subframe after frame", int'(subframe), ms);
                end else begin
                    mr++;
                end
            end else begin
                mc++;
            end
        end
    endtask

    task automatic t_reset();
        check_eq("R1", "valid", int'(valid), 0);
        check_eq("R1", "mask", int'(mask), 0);
        check_eq("R1", "eol", int'(eol), 0);
        check_eq("R1", "eof", int'(eof), 0);
        check_eq("R1", "error flag", int'(code_err), 0);
        check_eq("R1", "subframe", int'(subframe), 0);
        check_eq("R1", "column", int'(map_col), 0);
        check_eq("R1", "row", int'(map_row), 0);
    endtask

    task automatic t_raster();
        configure(5, 3, 1);
        run_pixels(30, 1);
        enable = 1'b0;
        check_eq("R2", "column after two frames", int'(map_col), 0);
    endtask

    // R5: 2x2 tile, top-right pixel owns phase 1
    task automatic t_two_by_two();
        configure(2, 2, 1);
        fixed_code = 1;
        for (int f = 0; f < 4; f++) begin
            int s0;
            s0 = ms;
            run_pixels(4, 1);
            check_eq("R5", "tile pattern", int'(frame_bits[3:0]), 1 << (s0 % 4));
            if (s0 % 4 == 1)
                check_eq("R5", "top-right exposed on phase 1", int'(frame_bits[1]), 1);
        end
        enable = 1'b0;
        fixed_code = -1;
    endtask

    task automatic t_coverage(int w, int h, int m);
        configure(w, h, m);
        for (int c = 0; c < 16; c++)
            for (int r = 0; r < 8; r++) cnt[c][r] = 0;
        run_pixels(w * h * (1 << (2 * m)), 1);
        enable = 1'b0;
        for (int c = 0; c < w; c++)
            for (int r = 0; r < h; r++)
                check_eq("R7", $sformatf("exposures of (%0d,%0d) m=%0d", c, r, m), cnt[c][r], 1);
    endtask

    task automatic t_idle();
        int s0;
        configure(4, 2, 1);
        run_pixels(3, 1);
        enable = 1'b0;
        s0 = int'(subframe);
        for (int i = 0; i < 5; i++) begin
            @(posedge clk);
            @(negedge clk);
            check_eq("R9", "valid while idle", int'(valid), 0);
            check_eq("R9", "eof while idle", int'(eof), 0);
            check_eq("R9", "column while idle", int'(map_col), 3);
            check_eq("R9", "subframe while idle", int'(subframe), s0);
        end
        run_pixels(5, 1);
        enable = 1'b0;
    endtask

    task automatic t_clamp();
        configure(4, 2, 1);
        check_eq("R8", "flag before bad code", int'(code_err), 0);
        bad_on = 1;
        run_pixels(8, 1);
        enable = 1'b0;
        check_eq("R8", "flag after bad code", int'(code_err), 1);
        bad_on = 0;
        run_pixels(16, 1);
        enable = 1'b0;
        check_eq("R8", "flag stays set", int'(code_err), 1);
    endtask

    task automatic t_wrap();
        configure(1, 1, 0);
        fixed_code = 0;
        for (int i = 0; i < 70000 && subframe != 16'hFFFF; i++) begin
            enable = 1'b1;
            @(posedge clk);
            @(negedge clk);
        end
        ms = int'(subframe);
        check_eq("R4", "subframe reached top", ms, 16'hFFFF);
        run_pixels(1, 1);
        enable = 1'b0;
        check_eq("R4", "subframe wrapped", int'(subframe), 0);
        fixed_code = -1;
    endtask

    initial begin
        cur_w = 4;
        cur_h = 2;
        cur_m = 0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_raster();
        t_two_by_two();
        t_coverage(3, 2, 0);
        t_coverage(7, 5, 1);
        t_coverage(12, 6, 2);
        t_coverage(16, 8, 3);
        t_idle();
        t_clamp();
        t_wrap();
        done = 1;
        summary();
        $finish;
    end
endmodule